// File: doc/BRIEF.md
# Matrix-Multiply Operand Index Sequencer

This block steps a multiply-accumulate loop through a whole matrix product Z = X * Y. For every loop step it gives three flattened element indices: one into the left matrix X, one into the right matrix Y, and one into the result Z. All three matrices are stored row by row in consecutive registers. The block does no arithmetic and never touches a register file. Its only job is to say which elements the current step combines.

Three sizes configure the product:

- dimX: the number of result columns, which is also the number of Y columns.
- dimY: the number of result rows, which is also the number of X rows.
- dimZ: the shared inner dimension, which is X columns and Y rows.

The loop order puts the inner-product term outermost. The result therefore sweeps its elements in row-major order once per inner term, so each result element is revisited and accumulated `dimZ` times.

A start strobe loads the sizes and three base offsets and makes the sequencer active at step 0. Each step strobe moves it one step forward. The final step is flagged. A step taken on the flagged step returns the sequencer to idle, where it waits for the next start.

Top module: `matidx_seq`

## Requirements
- R1: Each size input is taken as it stands when it lies in 1..64. A value of 0, or any value above 64, is replaced by 1. The `vecLen` output equals the product of the three sizes after this replacement.
- R2: A start accepted while idle makes `active` go high on the next clock edge. On that same edge, `stepCnt` becomes 0 and every index output equals its own base offset.
- R3: The innermost counter is the result column c (0..dimX-1). The middle counter is the result row r (0..dimY-1). The outermost counter is the inner term k (0..dimZ-1). `idxZ` equals baseZ + r*dimX + c.
- R4: `idxX` equals baseX + r*dimZ + k.
- R5: `idxY` equals baseY + k*dimX + c.
- R6: Each step strobe taken while active, other than on the final step, raises `stepCnt` by exactly one at the next edge.
- R7: `lastStep` is high exactly when the sequencer is active and `stepCnt` equals `vecLen` - 1.
- R8: A step strobe taken while `lastStep` is high drops `active` at the next edge. In idle, `stepCnt` and all three indices keep their final values.
- R9: A step strobe while idle has no effect. A start strobe while active is also ignored, and the sizes, bases, step count and indices are all left unchanged.
- R10: The base offsets are captured at start. A later change on the base inputs does not move the indices until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Load sizes and bases and begin at step 0 (ignored while active) |
| step | input | 1 | Move to the next loop step (ignored while idle) |
| dimX | input | DIN_W | Result column count (1..64; other values become 1) |
| dimY | input | DIN_W | Result row count (1..64; other values become 1) |
| dimZ | input | DIN_W | Inner dimension (1..64; other values become 1) |
| baseX | input | BASE_W | Base register offset for X |
| baseY | input | BASE_W | Base register offset for Y |
| baseZ | input | BASE_W | Base register offset for Z |
| idxX | output | OUT_W | Element index into X for the current step |
| idxY | output | OUT_W | Element index into Y for the current step |
| idxZ | output | OUT_W | Element index into Z for the current step |
| stepCnt | output | VL_W | Current step number |
| vecLen | output | VL_W | Total step count, dimX*dimY*dimZ |
| lastStep | output | 1 | Current step is the final one |
| active | output | 1 | Sequence in progress |

## Verification
Every output comes straight from a register, with no combinational path from any input. The effect of a start or step strobe is therefore due exactly one clock edge after the edge that samples it. The bench drives each strobe at a falling edge and releases it just after the next rising edge. At that point it queues the expected step number, indices, flag and length. The monitor compares them at the following falling edge, half a cycle after they were due and before any further change.

Ignored strobes are checked the same way. A start strobe during a run, or a step strobe while idle, queues the unchanged state for the same half-cycle-later sample.

// File: rtl/matidx_pkg.sv
package matidx_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic load;     // capture sizes and bases, clear counters
    logic advance;  // move to the next step (never on the final one)
    logic finish;   // step taken on the final step
  } seqStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

endpackage

// File: rtl/matidx_ctrl.sv
module matidx_ctrl
  import matidx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        step,
  input  logic        isLast,
  output seqStrobes_t strobes,
  output logic        active
);

  seqState_t state;

  assign active = (state == ST_RUN);

  always_comb begin
    strobes         = '0;
    strobes.load    = start && !active;
    strobes.advance = step && active && !isLast;
    strobes.finish  = step && active && isLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (strobes.load)   state <= ST_RUN;
        ST_RUN:  if (strobes.finish) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a step on the final step ends the run
  a_r8_finish_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (step && active && isLast) |=> !active);

  // R9: a start strobe during a run does not restart or stop it
  a_r9_start_ignored_when_run: assert property (@(posedge clk) disable iff (!rstN)
    (active && start && !step) |=> active);

endmodule

// File: rtl/matidx_dp.sv
module matidx_dp
  import matidx_pkg::*;
#(
  parameter int MAX_DIM = 64,
  parameter int DIN_W   = 8,
  parameter int BASE_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  input  logic [DIN_W-1:0]    dimXIn,
  input  logic [DIN_W-1:0]    dimYIn,
  input  logic [DIN_W-1:0]    dimZIn,
  input  logic [BASE_W-1:0]   baseXIn,
  input  logic [BASE_W-1:0]   baseYIn,
  input  logic [BASE_W-1:0]   baseZIn,
  output logic [((($clog2(MAX_DIM*MAX_DIM) > BASE_W) ? $clog2(MAX_DIM*MAX_DIM) : BASE_W) + 1)-1:0] idxX,
  output logic [((($clog2(MAX_DIM*MAX_DIM) > BASE_W) ? $clog2(MAX_DIM*MAX_DIM) : BASE_W) + 1)-1:0] idxY,
  output logic [((($clog2(MAX_DIM*MAX_DIM) > BASE_W) ? $clog2(MAX_DIM*MAX_DIM) : BASE_W) + 1)-1:0] idxZ,
  output logic [$clog2(MAX_DIM*MAX_DIM*MAX_DIM+1)-1:0] stepCnt,
  output logic [$clog2(MAX_DIM*MAX_DIM*MAX_DIM+1)-1:0] vecLen,
  output logic                isLast
);

  localparam int DIM_W = $clog2(MAX_DIM + 1);
  localparam int IDX_W = $clog2(MAX_DIM * MAX_DIM);
  localparam int OUT_W = ((IDX_W > BASE_W) ? IDX_W : BASE_W) + 1;
  localparam int VL_W  = $clog2(MAX_DIM * MAX_DIM * MAX_DIM + 1);

  function automatic logic [DIM_W-1:0] clampDim(input logic [DIN_W-1:0] raw);
    if (raw == '0 || raw > DIN_W'(MAX_DIM)) return DIM_W'(1);
    return DIM_W'(raw);
  endfunction

  logic [DIM_W-1:0]  xDimN, yDimN, zDimN;
  logic [DIM_W-1:0]  xDim, yDim, zDim;
  logic [DIM_W-1:0]  cCnt, rCnt, kCnt;
  logic [IDX_W-1:0]  xRowOff;   // r*zDim
  logic [IDX_W-1:0]  yRowOff;   // k*xDim
  logic [IDX_W-1:0]  zRowOff;   // r*xDim
  logic [BASE_W-1:0] baseXr, baseYr, baseZr;
  logic              cWrap, rWrap;

  assign xDimN = clampDim(dimXIn);
  assign yDimN = clampDim(dimYIn);
  assign zDimN = clampDim(dimZIn);

  assign cWrap  = (cCnt == xDim - DIM_W'(1));
  assign rWrap  = (rCnt == yDim - DIM_W'(1));
  assign isLast = (stepCnt == vecLen - VL_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xDim    <= DIM_W'(1);
      yDim    <= DIM_W'(1);
      zDim    <= DIM_W'(1);
      vecLen  <= VL_W'(1);
      baseXr  <= '0;
      baseYr  <= '0;
      baseZr  <= '0;
      cCnt    <= '0;
      rCnt    <= '0;
      kCnt    <= '0;
      xRowOff <= '0;
      yRowOff <= '0;
      zRowOff <= '0;
      stepCnt <= '0;
    end else if (strobes.load) begin
      xDim    <= xDimN;
      yDim    <= yDimN;
      zDim    <= zDimN;
      vecLen  <= VL_W'(xDimN) * VL_W'(yDimN) * VL_W'(zDimN);
      baseXr  <= baseXIn;
      baseYr  <= baseYIn;
      baseZr  <= baseZIn;
      cCnt    <= '0;
      rCnt    <= '0;
      kCnt    <= '0;
      xRowOff <= '0;
      yRowOff <= '0;
      zRowOff <= '0;
      stepCnt <= '0;
    end else if (strobes.advance) begin
      stepCnt <= stepCnt + VL_W'(1);
      if (!cWrap) begin
        cCnt <= cCnt + DIM_W'(1);
      end else begin
        cCnt <= '0;
        if (!rWrap) begin
          rCnt    <= rCnt + DIM_W'(1);
          xRowOff <= xRowOff + IDX_W'(zDim);
          zRowOff <= zRowOff + IDX_W'(xDim);
        end else begin
          rCnt    <= '0;
          xRowOff <= '0;
          zRowOff <= '0;
          kCnt    <= kCnt + DIM_W'(1);
          yRowOff <= yRowOff + IDX_W'(xDim);
        end
      end
    end
  end

  assign idxX = OUT_W'(baseXr) + OUT_W'(xRowOff) + OUT_W'(kCnt);
  assign idxY = OUT_W'(baseYr) + OUT_W'(yRowOff) + OUT_W'(cCnt);
  assign idxZ = OUT_W'(baseZr) + OUT_W'(zRowOff) + OUT_W'(cCnt);

  // R1: captured sizes always lie in 1..MAX_DIM
  a_r1_dim_range: assert property (@(posedge clk) disable iff (!rstN)
    (xDim >= DIM_W'(1)) && (xDim <= DIM_W'(MAX_DIM)) &&
    (yDim >= DIM_W'(1)) && (yDim <= DIM_W'(MAX_DIM)) &&
    (zDim >= DIM_W'(1)) && (zDim <= DIM_W'(MAX_DIM)));

  // R3: loop counters stay inside their dimensions
  a_r3_counter_range: assert property (@(posedge clk) disable iff (!rstN)
    (cCnt < xDim) && (rCnt < yDim) && (kCnt < zDim));

  // R2: a load clears the step count and all loop counters
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (stepCnt == '0) && (cCnt == '0) && (rCnt == '0) && (kCnt == '0));

  // R6: an advance raises the step count by one
  a_r6_step_increment: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> (stepCnt == $past(stepCnt) + VL_W'(1)));

  // R4: row offsets are zero whenever the row counter is zero
  a_r4_row_offset_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rCnt == '0) |-> (xRowOff == '0) && (zRowOff == '0));

endmodule

// File: rtl/matidx_seq.sv
module matidx_seq
  import matidx_pkg::*;
#(
  parameter int MAX_DIM = 64,
  parameter int DIN_W   = 8,
  parameter int BASE_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              step,
  input  logic [DIN_W-1:0]  dimX,
  input  logic [DIN_W-1:0]  dimY,
  input  logic [DIN_W-1:0]  dimZ,
  input  logic [BASE_W-1:0] baseX,
  input  logic [BASE_W-1:0] baseY,
  input  logic [BASE_W-1:0] baseZ,
  output logic [((($clog2(MAX_DIM*MAX_DIM) > BASE_W) ? $clog2(MAX_DIM*MAX_DIM) : BASE_W) + 1)-1:0] idxX,
  output logic [((($clog2(MAX_DIM*MAX_DIM) > BASE_W) ? $clog2(MAX_DIM*MAX_DIM) : BASE_W) + 1)-1:0] idxY,
  output logic [((($clog2(MAX_DIM*MAX_DIM) > BASE_W) ? $clog2(MAX_DIM*MAX_DIM) : BASE_W) + 1)-1:0] idxZ,
  output logic [$clog2(MAX_DIM*MAX_DIM*MAX_DIM+1)-1:0] stepCnt,
  output logic [$clog2(MAX_DIM*MAX_DIM*MAX_DIM+1)-1:0] vecLen,
  output logic              lastStep,
  output logic              active
);

  seqStrobes_t strobes;
  logic        isLast;

  matidx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .step    (step),
    .isLast  (isLast),
    .strobes (strobes),
    .active  (active)
  );

  matidx_dp #(
    .MAX_DIM (MAX_DIM),
    .DIN_W   (DIN_W),
    .BASE_W  (BASE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dimXIn  (dimX),
    .dimYIn  (dimY),
    .dimZIn  (dimZ),
    .baseXIn (baseX),
    .baseYIn (baseY),
    .baseZIn (baseZ),
    .idxX    (idxX),
    .idxY    (idxY),
    .idxZ    (idxZ),
    .stepCnt (stepCnt),
    .vecLen  (vecLen),
    .isLast  (isLast)
  );

  assign lastStep = isLast && active;

  // R7: the final-step flag is only ever seen during a run
  a_r7_last_needs_active: assert property (@(posedge clk) disable iff (!rstN)
    lastStep |-> active);

  // R9: while idle and not started, step count and indices hold
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !start) |=> $stable(stepCnt) && $stable(idxX) && $stable(idxY) && $stable(idxZ));

endmodule

// File: tb/matidx_seq_bench.sv
module matidx_seq_bench;

  localparam int MAX_DIM = 64;
  localparam int DIN_W   = 8;
  localparam int BASE_W  = 12;
  localparam int IDX_W   = $clog2(MAX_DIM * MAX_DIM);
  localparam int OUT_W   = ((IDX_W > BASE_W) ? IDX_W : BASE_W) + 1;
  localparam int VL_W    = $clog2(MAX_DIM * MAX_DIM * MAX_DIM + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              step = 1'b0;
  logic [DIN_W-1:0]  dimX = '0, dimY = '0, dimZ = '0;
  logic [BASE_W-1:0] baseX = '0, baseY = '0, baseZ = '0;
  logic [OUT_W-1:0]  idxX, idxY, idxZ;
  logic [VL_W-1:0]   stepCnt, vecLen;
  logic              lastStep, active;

  always #2 clk = ~clk;  // 250 MHz

  matidx_seq #(.MAX_DIM(MAX_DIM), .DIN_W(DIN_W), .BASE_W(BASE_W)) u_matidx_seq (
    .clk(clk), .rstN(rstN), .start(start), .step(step),
    .dimX(dimX), .dimY(dimY), .dimZ(dimZ),
    .baseX(baseX), .baseY(baseY), .baseZ(baseZ),
    .idxX(idxX), .idxY(idxY), .idxZ(idxZ),
    .stepCnt(stepCnt), .vecLen(vecLen), .lastStep(lastStep), .active(active)
  );

  typedef struct {
    int act;
    int lst;
    int stp;
    int vl;
    int x;
    int y;
    int z;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int       checks = 0;
  int       errors = 0;
  int       cycles = 0;
  expItem_t lastExp;

  function automatic int clampB(input int v);
    if (v == 0 || v > MAX_DIM) return 1;
    return v;
  endfunction

  task automatic pushExp(input expItem_t e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    lastExp = e;
  endtask

  // Monitor: compares one queued item per falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      string    t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (int'(active) != e.act || int'(lastStep) != e.lst || int'(stepCnt) != e.stp ||
          int'(vecLen) != e.vl || int'(idxX) != e.x || int'(idxY) != e.y || int'(idxZ) != e.z) begin
        errors++;
        $display("FAIL %s: act/last/step/vl/x/y/z actual %0d/%0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d/%0d",
                 t, active, lastStep, stepCnt, vecLen, idxX, idxY, idxZ,
                 e.act, e.lst, e.stp, e.vl, e.x, e.y, e.z);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse(input bit doStart, input bit doStep);
    @(negedge clk);
    start = doStart;
    step  = doStep;
    @(posedge clk);
    #1;
    start = 1'b0;
    step  = 1'b0;
  endtask

  // Driver: runs a full product; interruptAt >= 0 inserts an ignored start there
  task automatic runProduct(input int xdIn, input int ydIn, input int zdIn,
                            input int bx, input int by, input int bz,
                            input int interruptAt);
    int xd, yd, zd, vl, s;
    expItem_t e;
    xd = clampB(xdIn);
    yd = clampB(ydIn);
    zd = clampB(zdIn);
    vl = xd * yd * zd;
    @(negedge clk);
    dimX = DIN_W'(xdIn); dimY = DIN_W'(ydIn); dimZ = DIN_W'(zdIn);
    baseX = BASE_W'(bx); baseY = BASE_W'(by); baseZ = BASE_W'(bz);
    s = 0;
    for (int k = 0; k < zd; k++) begin
      for (int r = 0; r < yd; r++) begin
        for (int c = 0; c < xd; c++) begin
          if (s == 0) pulse(1'b1, 1'b0);
          else        pulse(1'b0, 1'b1);
          if (s == 1) begin
            // R10: base inputs moved after start must not affect indices
            baseX = BASE_W'(bx + 100); baseY = BASE_W'(by + 200); baseZ = BASE_W'(bz + 300);
          end
          e.act = 1; e.lst = (s == vl - 1) ? 1 : 0; e.stp = s; e.vl = vl;
          e.x = bx + r * zd + k;
          e.y = by + k * xd + c;
          e.z = bz + r * xd + c;
          pushExp(e, (s == 0) ? "R1 R2 R10" : "R3 R4 R5 R6 R7 R10");
          if (s == interruptAt) begin
            dimX = 8'd5; dimY = 8'd5; dimZ = 8'd5;
            pulse(1'b1, 1'b0);
            pushExp(e, "R9 start while active");
          end
          s++;
        end
      end
    end
    // final step ends the run; state holds
    pulse(1'b0, 1'b1);
    e = lastExp;
    e.act = 0; e.lst = 0;
    pushExp(e, "R8 idle after last");
    // step while idle is ignored
    pulse(1'b0, 1'b1);
    pushExp(e, "R9 step while idle");
  endtask

  initial begin
    expItem_t e;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(posedge clk);
    #1;
    e.act = 0; e.lst = 0; e.stp = 0; e.vl = 1; e.x = 0; e.y = 0; e.z = 0;
    pushExp(e, "R2 reset state");

    // 2x3 times 3x2: result 2x2, inner 3
    runProduct(2, 2, 3, 16, 32, 0, -1);
    // non-square with offsets and an ignored start mid-run
    runProduct(3, 2, 4, 7, 50, 90, 5);
    // R1 clamps: 0 -> 1, 100 -> 1
    runProduct(0, 100, 3, 1, 2, 3, -1);
    // R7 single-element product: last on step 0
    runProduct(1, 1, 1, 10, 20, 30, -1);
    // R1 upper boundary 64 kept, 65 clamped
    runProduct(64, 65, 1, 0, 0, 0, -1);
    runProduct(2, 1, 64, 4, 8, 12, -1);

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule